// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block decides when an analog-to-digital conversion sequence begins. It watches a software start strobe and an asynchronous external trigger pin, and, under a small set of mode controls, issues single-cycle launch pulses to a separate sequence engine. It reads back that engine's busy and done signals, so it never launches on top of a running sequence.

Three sources of work are recognised. With the external trigger disabled, software starts either one sequence per strobe or, with the scan control set, an endless chain of back-to-back sequences. With the trigger enabled, either a chosen edge (falling or rising) launches exactly one sequence, or a chosen level (low or high) keeps sequences running for as long as it is held. An edge that arrives while a sequence is still in flight is dropped and recorded in a sticky overrun flag. In level mode a level that drops and returns inside a sequence is never an overrun. All pins are plain control and status signals: the launch is a one-cycle strobe that the engine must accept, and there is no valid/ready stream at this boundary.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, seq_start is 0 and ovr_flag is 0.
- R2: With trig_en=0 and scan_en=0, each sw_start pulse launches exactly one sequence and ext_trig has no effect on seq_start.
- R3: With trig_en=0 and scan_en=1, one sw_start pulse starts sequences that repeat back to back until scan_en returns to 0.
- R4: With trig_en=1, lvl_mode=0, trig_pol=0, each falling edge of ext_trig launches one sequence and a rising edge launches none.
- R5: With trig_en=1, lvl_mode=0, trig_pol=1, each rising edge of ext_trig launches one sequence.
- R6: With trig_en=1, lvl_mode=1, ext_trig is active low for trig_pol=0 and active high for trig_pol=1; while it is active, sequences repeat, and the next seq_start comes in the cycle right after a seq_done cycle.
- R7: While trig_en=1, sw_start launches no sequence.
- R8: In edge mode, an active edge seen while a launched sequence has not yet reported seq_done sets ovr_flag and launches nothing.
- R9: In level mode, ovr_flag is never set, including when ext_trig drops and returns during a sequence.
- R10: ovr_flag stays 1 until ovr_clr is 1; ovr_clr=1 clears it in the next cycle, except that a new overrun in the same cycle keeps it set.
- R11: seq_start is high for exactly one cycle and is not raised again before the engine reports seq_done for the sequence it launched.
- R12: ext_trig passes a two-stage synchronizer; a qualifying edge driven between clock edges gives seq_start=1 after the third following rising clock edge, when the engine is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 1 | Asynchronous external trigger |
| trig_en | input | 1 | 1 selects external triggering |
| lvl_mode | input | 1 | 1 = level triggered, 0 = edge triggered |
| trig_pol | input | 1 | 1 = rising/high active, 0 = falling/low active |
| scan_en | input | 1 | Continuous software sequences |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| seq_busy | input | 1 | Sequence engine busy |
| seq_done | input | 1 | Sequence engine finishing this cycle |
| seq_start | output | 1 | One-cycle sequence launch |
| ovr_flag | output | 1 | Sticky overrun error |

## Verification
The launch logic is driven with a single software strobe, a continuous software scan, slow full trigger cycles, a lone rising edge, a held level and a fast burst of short pulses inside one sequence. The lone rising edge separates the two edge polarities; the slow cycles show one launch per edge; the held level against the scan shows which source keeps the chain alive; and the fast burst run in edge and level mode tells a true overrun from a harmless level glitch. Directed tests pin down the synchronizer latency, the restart in the cycle after done, and set-over-clear priority on the flag.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_EDGE  = 2'd1,
    SRC_LEVEL = 2'd2
  } trig_src_e;

  function automatic trig_src_e pick_src(input logic en, input logic lvl);
    if (!en)     return SRC_SOFT;
    else if (lvl) return SRC_LEVEL;
    else          return SRC_EDGE;
  endfunction
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev_q;
  assign fall  = ~chain[LAST] & prev_q;

  a_r12_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
  a_r12_rise_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/adc_trig_launch.sv
module adc_trig_launch
  import adc_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_e src,
  input  logic      scan_en,
  input  logic      sw_start,
  input  logic      hit_edge,
  input  logic      hit_level,
  input  logic      seq_busy,
  input  logic      seq_done,
  output logic      seq_start,
  output logic      in_flight
);
  logic pend_q, chain_q, start_q, run_q;
  logic engine_free, want, go;

  assign engine_free = (~run_q & ~seq_busy) | seq_done;

  always_comb begin
    unique case (src)
      SRC_SOFT:  want = pend_q | sw_start | chain_q;
      SRC_EDGE:  want = hit_edge;
      SRC_LEVEL: want = hit_level;
      default:   want = 1'b0;
    endcase
  end

  assign go = want & engine_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      chain_q <= 1'b0;
      start_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      start_q <= go;
      if (go)            run_q <= 1'b1;
      else if (seq_done) run_q <= 1'b0;

      if (src != SRC_SOFT || go) pend_q <= 1'b0;
      else if (sw_start)         pend_q <= 1'b1;

      if (src != SRC_SOFT || !scan_en)  chain_q <= 1'b0;
      else if (sw_start)                chain_q <= 1'b1;
    end
  end

  assign seq_start = start_q;
  assign in_flight = run_q;

  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !seq_done) |=> !seq_start);
  a_r7_soft_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_SOFT && !hit_edge && !hit_level) |=> !seq_start);
endmodule

// File: rtl/adc_trig_overrun.sv
module adc_trig_overrun
  import adc_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_e src,
  input  logic      hit_edge,
  input  logic      in_flight,
  input  logic      seq_done,
  input  logic      ovr_clr,
  output logic      ovr_flag
);
  logic flag_q, raise;

  assign raise = (src == SRC_EDGE) & hit_edge & in_flight & ~seq_done;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (raise)   flag_q <= 1'b1;
    else if (ovr_clr) flag_q <= 1'b0;
  end

  assign ovr_flag = flag_q;

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  a_r9_level_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_LEVEL && !ovr_flag) |=> !ovr_flag);
  a_r8_needs_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_flight && !ovr_flag) |=> !ovr_flag);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic ext_trig,
  input  logic trig_en,
  input  logic lvl_mode,
  input  logic trig_pol,
  input  logic scan_en,
  input  logic ovr_clr,
  input  logic seq_busy,
  input  logic seq_done,
  output logic seq_start,
  output logic ovr_flag
);
  trig_src_e src;
  logic      s_level, s_rise, s_fall;
  logic      hit_edge, hit_level, in_flight;

  assign src       = pick_src(trig_en, lvl_mode);
  assign hit_edge  = trig_pol ? s_rise  : s_fall;
  assign hit_level = trig_pol ? s_level : ~s_level;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_trig),
    .level    (s_level),
    .rise     (s_rise),
    .fall     (s_fall)
  );

  adc_trig_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .scan_en   (scan_en),
    .sw_start  (sw_start),
    .hit_edge  (hit_edge),
    .hit_level (hit_level),
    .seq_busy  (seq_busy),
    .seq_done  (seq_done),
    .seq_start (seq_start),
    .in_flight (in_flight)
  );

  adc_trig_overrun u_ovr (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .hit_edge  (hit_edge),
    .in_flight (in_flight),
    .seq_done  (seq_done),
    .ovr_clr   (ovr_clr),
    .ovr_flag  (ovr_flag)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!seq_start && !ovr_flag));
endmodule

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;
  localparam int BUSY_LEN = 6;

  localparam logic [2:0] P_SW = 3'd0, P_TOGGLE = 3'd1, P_SCAN = 3'd2, P_RISE = 3'd3,
                         P_EDGES = 3'd4, P_HOLD = 3'd5, P_BURST = 3'd6;

  typedef struct packed {
    logic       en;
    logic       lvl;
    logic       pol;
    logic       scan;
    logic [2:0] pat;
    logic [3:0] lo;
    logic [3:0] hi;
    logic       ovr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, P_SW,     4'd1, 4'd1, 1'b0, 4'd2 },  // R2
    '{1'b0,1'b0,1'b0,1'b0, P_TOGGLE, 4'd0, 4'd0, 1'b0, 4'd2 },  // R2
    '{1'b0,1'b0,1'b0,1'b1, P_SCAN,   4'd4, 4'd8, 1'b0, 4'd3 },  // R3
    '{1'b1,1'b0,1'b0,1'b0, P_RISE,   4'd0, 4'd0, 1'b0, 4'd4 },  // R4
    '{1'b1,1'b0,1'b0,1'b0, P_EDGES,  4'd2, 4'd2, 1'b0, 4'd4 },  // R4
    '{1'b1,1'b0,1'b1,1'b0, P_RISE,   4'd1, 4'd1, 1'b0, 4'd5 },  // R5
    '{1'b1,1'b0,1'b1,1'b0, P_EDGES,  4'd2, 4'd2, 1'b0, 4'd5 },  // R5
    '{1'b1,1'b1,1'b1,1'b0, P_HOLD,   4'd4, 4'd8, 1'b0, 4'd6 },  // R6
    '{1'b1,1'b1,1'b0,1'b0, P_HOLD,   4'd4, 4'd8, 1'b0, 4'd6 },  // R6
    '{1'b1,1'b0,1'b1,1'b0, P_SW,     4'd0, 4'd0, 1'b0, 4'd7 },  // R7
    '{1'b1,1'b1,1'b1,1'b0, P_SW,     4'd0, 4'd0, 1'b0, 4'd7 },  // R7
    '{1'b1,1'b0,1'b1,1'b0, P_BURST,  4'd1, 4'd1, 1'b1, 4'd8 },  // R8
    '{1'b1,1'b0,1'b0,1'b0, P_BURST,  4'd1, 4'd1, 1'b1, 4'd8 },  // R8
    '{1'b1,1'b1,1'b1,1'b0, P_BURST,  4'd1, 4'd1, 1'b0, 4'd9 }   // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 1'b0, ext_trig = 1'b0, trig_en = 1'b0, lvl_mode = 1'b0;
  logic trig_pol = 1'b0, scan_en = 1'b0, ovr_clr = 1'b0;
  logic seq_busy, seq_done, seq_start, ovr_flag;

  int checks = 0;
  int errors = 0;
  int starts_total = 0;
  int ovr_cycles = 0;
  int eng_cnt;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .ext_trig(ext_trig),
    .trig_en(trig_en), .lvl_mode(lvl_mode), .trig_pol(trig_pol), .scan_en(scan_en),
    .ovr_clr(ovr_clr), .seq_busy(seq_busy), .seq_done(seq_done),
    .seq_start(seq_start), .ovr_flag(ovr_flag)
  );

  // sequence engine model: fixed busy window, done on its last cycle
  always_ff @(posedge clk) begin
    if (!rst_n)             eng_cnt <= 0;
    else if (seq_start)     eng_cnt <= BUSY_LEN;
    else if (eng_cnt != 0)  eng_cnt <= eng_cnt - 1;
  end
  assign seq_busy = (eng_cnt != 0);
  assign seq_done = (eng_cnt == 1);

  always @(negedge clk) begin
    if (seq_start) starts_total++;
    if (ovr_flag)  ovr_cycles++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ext(input logic v, input int hold);
    ext_trig = v;
    cyc(hold);
  endtask

  task automatic quiesce();
    trig_en = 1'b0; lvl_mode = 1'b0; scan_en = 1'b0; sw_start = 1'b0;
    cyc(4);
    ext_trig = 1'b0;
    cyc(20);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0; cyc(2);
  endtask

  task automatic run_vec(input vec_t v);
    int base;
    quiesce();
    ext_trig = (v.en && v.lvl) ? ~v.pol : 1'b0;
    cyc(6);
    trig_pol = v.pol; lvl_mode = v.lvl; scan_en = v.scan; trig_en = v.en;
    cyc(6);
    base = starts_total;
    case (v.pat)
      P_SW:     begin sw_start = 1'b1; cyc(1); sw_start = 1'b0; cyc(30); end
      P_TOGGLE: for (int k = 0; k < 4; k++) set_ext(~ext_trig, 5);
      P_SCAN:   begin sw_start = 1'b1; cyc(1); sw_start = 1'b0; cyc(40); scan_en = 1'b0; end
      P_RISE:   set_ext(1'b1, 30);
      P_EDGES:  begin set_ext(1'b1, 20); set_ext(1'b0, 20); set_ext(1'b1, 20); set_ext(1'b0, 20); end
      P_HOLD:   begin set_ext(v.pol, 40); set_ext(~v.pol, 2); end
      P_BURST:  begin set_ext(1'b1, 2); set_ext(1'b0, 2); set_ext(1'b1, 2); set_ext(1'b0, 2); end
      default:  cyc(1);
    endcase
    cyc(30);
    chk(starts_total - base >= int'(v.lo) && starts_total - base <= int'(v.hi),
        $sformatf("R%0d starts", v.req), starts_total - base, int'(v.lo));
    chk(ovr_flag == v.ovr, $sformatf("R%0d overrun", v.req), ovr_flag, v.ovr);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, ovr_base;
    cyc(5);
    // R1 reset state
    chk(seq_start == 1'b0, "R1 seq_start", seq_start, 0);
    chk(ovr_flag == 1'b0, "R1 ovr_flag", ovr_flag, 0);
    rst_n = 1'b1;
    cyc(3);
    chk(seq_start == 1'b0 && ovr_flag == 1'b0, "R1 idle", seq_start, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12: synchronizer latency on a rising edge
    quiesce();
    trig_pol = 1'b1; trig_en = 1'b1; cyc(6);
    ext_trig = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk(seq_start == 1'b0, "R12 early", seq_start, 0);
    @(posedge clk);
    #1 chk(seq_start == 1'b1, "R12 third edge", seq_start, 1);
    @(posedge clk);
    #1 chk(seq_start == 1'b0, "R11 one cycle", seq_start, 0);

    // R6: restart in the cycle after done while level held
    quiesce();
    ext_trig = 1'b0; cyc(6);
    trig_pol = 1'b1; lvl_mode = 1'b1; trig_en = 1'b1;
    ext_trig = 1'b1;
    cyc(10);
    while (!seq_done) @(negedge clk);
    @(negedge clk);
    chk(seq_start == 1'b1, "R6 immediate restart", seq_start, 1);
    ext_trig = 1'b0;

    // R10: sticky until cleared
    quiesce();
    trig_pol = 1'b1; trig_en = 1'b1; cyc(6);
    set_ext(1'b1, 2); set_ext(1'b0, 2); set_ext(1'b1, 2); set_ext(1'b0, 2);
    cyc(50);
    chk(ovr_flag == 1'b1, "R10 sticky", ovr_flag, 1);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R10 clear", ovr_flag, 0);

    // R10: set wins over a clear held in the same cycle
    quiesce();
    trig_pol = 1'b1; trig_en = 1'b1; cyc(6);
    ovr_clr = 1'b1;
    ovr_base = ovr_cycles;
    set_ext(1'b1, 2); set_ext(1'b0, 2); set_ext(1'b1, 2); set_ext(1'b0, 2);
    cyc(10);
    chk(ovr_cycles - ovr_base >= 1, "R10 set wins", ovr_cycles - ovr_base, 1);
    chk(ovr_flag == 1'b0, "R10 clear held", ovr_flag, 0);
    ovr_clr = 1'b0;

    // R11: second strobe during a sequence waits for done
    quiesce();
    base = starts_total;
    sw_start = 1'b1; cyc(1); sw_start = 1'b0; cyc(2);
    sw_start = 1'b1; cyc(1); sw_start = 1'b0; cyc(30);
    chk(starts_total - base == 2, "R11 queued start", starts_total - base, 2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule